// File: doc/BRIEF.md
# Shared Ingress Rate Bucket Policer

This block polices the combined ingress traffic of a group of switch ports with one leaky bucket. Every frame from a member port adds a charge to a 24-bit bucket level. The charge is the frame length plus a per-frame overhead, multiplied by a programmable increment. A periodic update tick drains the level by a programmable rate factor. The block returns a verdict for every frame strobe, one cycle after the strobe.

When a frame would push the level above the excess limit, the configured action applies. In drop mode the frame is marked for discard and is not charged. In flow-control mode the frame passes and is charged, and a flow-control request is raised on the port that sent it. Each port has its own release rule for that request. It is released either when the bucket has drained to empty, or when the level is back at or below the committed limit.

All configuration inputs are static while traffic flows. A synchronous init input clears the bucket and every pending flow-control request.

Top module: `ingress_bucket_policer`

## Requirements
- R1: A charged frame raises the level by (frm_len_i + cfg_ovh_i) × cfg_incr_i. The only valid overhead codes are 1, 2 and 6.
- R2: The level saturates at 2^24−1 and never wraps.
- R3: Each cycle with tick_i high lowers the level by cfg_rate_i, with a floor of zero. When a tick and a frame arrive in the same cycle, the drain is applied first and the frame is then judged on the drained level.
- R4: Every cycle with frm_valid_i high produces exactly one verdict: verdict_valid_o is high in the next cycle. A frame is over limit only when the new level is strictly greater than cfg_excess_i, so a level equal to the limit passes.
- R5: With cfg_fc_mode_i = 0 (drop mode), an over-limit frame gets verdict_drop_o = 1 and leaves the level unchanged.
- R6: A frame is not charged and gets verdict_drop_o = 0 in either of two cases: its port's bit in cfg_member_i is 0 (bit p belongs to port p), or cfg_ovh_i holds an invalid code.
- R7: A frame flagged frm_filtered_i is charged only when cfg_chg_filt_i = 1. A frame flagged frm_qdrop_i is charged only when cfg_chg_qdrop_i = 1. A frame that is not charged gets verdict_drop_o = 0.
- R8: With cfg_fc_mode_i = 1, an over-limit frame gets verdict_drop_o = 0 and is charged. fc_req_o[p] for its port p rises in the next cycle.
- R9: A raised fc_req_o[p] is released according to cfg_release_i[p]. With the bit at 0, it releases when the level equals zero. With the bit at 1, it releases when the level is at or below cfg_commit_i. The release is judged on the registered level and takes effect one cycle after that level is reached.
- R10: While init_i is high, the level is cleared to zero and all fc_req_o bits are cleared in the next cycle. A frame strobed during init_i is not charged and gets verdict_drop_o = 0.
- R11: After reset, the level is zero, fc_req_o is all zero and verdict_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous clear of the bucket and the flow-control state |
| tick_i | input | 1 | Drain update strobe |
| frm_valid_i | input | 1 | Frame arrival strobe |
| frm_port_i | input | PORT_IDX_W | Ingress port of the frame |
| frm_len_i | input | LEN_W | Frame length in bytes |
| frm_filtered_i | input | 1 | Frame has been filtered |
| frm_qdrop_i | input | 1 | Frame has been discarded for queue congestion |
| cfg_incr_i | input | INC_W | Increment per counted byte |
| cfg_rate_i | input | RATE_W | Drain amount per tick |
| cfg_commit_i | input | LEVEL_W | Committed burst limit |
| cfg_excess_i | input | LEVEL_W | Excess burst limit |
| cfg_fc_mode_i | input | 1 | Over-limit action: 0 drop, 1 flow control |
| cfg_release_i | input | NUM_PORTS | Per-port release rule: 0 at empty, 1 at committed limit |
| cfg_member_i | input | NUM_PORTS | Ports that share this bucket |
| cfg_ovh_i | input | 4 | Per-frame overhead code (1, 2 or 6) |
| cfg_chg_filt_i | input | 1 | Charge filtered frames |
| cfg_chg_qdrop_i | input | 1 | Charge congestion-discarded frames |
| verdict_valid_o | output | 1 | Verdict for the frame of the previous cycle |
| verdict_drop_o | output | 1 | Discard the frame |
| fc_req_o | output | NUM_PORTS | Per-port flow-control request |

## Verification
The bench uses the default parameters: four ports, a 12-bit frame length, a 12-bit increment, a 16-bit rate factor and a 24-bit level. These widths make a single frame of length 4095 with overhead 6 and increment 4095 overrun the 24-bit level, so one frame is enough to reach saturation. The four ports also allow two members and two non-members in one run. The members can then be given opposite release rules, so the empty release and the committed-limit release both occur within one drain sequence.

// File: rtl/ibp_pkg.sv
package ibp_pkg;

  localparam int OVH_W = 4;

  // Overhead codes accepted by the policer
  function automatic logic ovh_code_ok(input logic [OVH_W-1:0] code);
    return (code == 4'd1) || (code == 4'd2) || (code == 4'd6);
  endfunction

endpackage

// File: rtl/ibp_charge_calc.sv
module ibp_charge_calc
  import ibp_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int PORT_IDX_W = 2,
  parameter int LEN_W      = 12,
  parameter int INC_W      = 12,
  parameter int CHG_W      = LEN_W + 1 + INC_W
) (
  input  logic                  frm_valid_i,
  input  logic [PORT_IDX_W-1:0] frm_port_i,
  input  logic [LEN_W-1:0]      frm_len_i,
  input  logic                  frm_filtered_i,
  input  logic                  frm_qdrop_i,
  input  logic                  init_i,
  input  logic [NUM_PORTS-1:0]  cfg_member_i,
  input  logic [OVH_W-1:0]      cfg_ovh_i,
  input  logic [INC_W-1:0]      cfg_incr_i,
  input  logic                  cfg_chg_filt_i,
  input  logic                  cfg_chg_qdrop_i,
  output logic                  charge_en_o,
  output logic [CHG_W-1:0]      charge_o
);

  localparam int BYTES_W = LEN_W + 1;

  logic               port_in_range;
  logic               is_member;
  logic               flags_ok;
  logic [BYTES_W-1:0] counted_bytes;

  always_comb begin
    port_in_range = (32'(frm_port_i) < NUM_PORTS);
    is_member     = port_in_range && cfg_member_i[frm_port_i];
    flags_ok      = (!frm_filtered_i || cfg_chg_filt_i) &&
                    (!frm_qdrop_i    || cfg_chg_qdrop_i);
    charge_en_o   = frm_valid_i && !init_i && is_member &&
                    ovh_code_ok(cfg_ovh_i) && flags_ok;
    counted_bytes = {1'b0, frm_len_i} + BYTES_W'(cfg_ovh_i);
    charge_o      = CHG_W'(counted_bytes) * CHG_W'(cfg_incr_i);
  end

endmodule

// File: rtl/ibp_bucket_level.sv
module ibp_bucket_level #(
  parameter int LEVEL_W = 24,
  parameter int RATE_W  = 16,
  parameter int CHG_W   = 25,
  parameter int SUM_W   = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic               tick_i,
  input  logic               charge_en_i,
  input  logic [CHG_W-1:0]   charge_i,
  input  logic [RATE_W-1:0]  cfg_rate_i,
  input  logic [LEVEL_W-1:0] cfg_excess_i,
  input  logic               cfg_fc_mode_i,
  output logic [LEVEL_W-1:0] level_o,
  output logic               over_o
);

  localparam logic [LEVEL_W-1:0] LEVEL_MAX = '1;

  logic [LEVEL_W-1:0] level_q, level_d;
  logic [LEVEL_W-1:0] rate_ext, drained, sat_sum;
  logic [SUM_W-1:0]   raw_sum;
  logic               take, level_en;

  always_comb begin
    rate_ext = LEVEL_W'(cfg_rate_i);
    drained  = level_q;
    if (tick_i) begin
      drained = (level_q > rate_ext) ? (level_q - rate_ext) : '0;
    end
    raw_sum  = SUM_W'(drained) + SUM_W'(charge_i);
    sat_sum  = (raw_sum > SUM_W'(LEVEL_MAX)) ? LEVEL_MAX : raw_sum[LEVEL_W-1:0];
    over_o   = charge_en_i && (sat_sum > cfg_excess_i);
    take     = charge_en_i && !init_i && !(over_o && !cfg_fc_mode_i);
    level_en = init_i || tick_i || take;
    level_d  = init_i ? '0 : (take ? sat_sum : drained);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
    end else if (level_en) begin
      level_q <= level_d;
    end
  end

  assign level_o = level_q;

  AST_LEVEL_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (level_q == '0)); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!charge_en_i && !tick_i && !init_i) |=> $stable(level_q)); // R6
  AST_DROP_NO_CHARGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (charge_en_i && over_o && !cfg_fc_mode_i && !tick_i && !init_i) |=> $stable(level_q)); // R5
  AST_TICK_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !charge_en_i && !init_i) |=> (level_q <= $past(level_q))); // R3

endmodule

// File: rtl/ibp_fc_tracker.sv
module ibp_fc_tracker #(
  parameter int NUM_PORTS = 4,
  parameter int LEVEL_W   = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 init_i,
  input  logic [NUM_PORTS-1:0] set_i,
  input  logic [LEVEL_W-1:0]   level_i,
  input  logic [LEVEL_W-1:0]   cfg_commit_i,
  input  logic [NUM_PORTS-1:0] cfg_release_i,
  output logic [NUM_PORTS-1:0] fc_o
);

  logic at_empty, under_commit;

  always_comb begin
    at_empty     = (level_i == '0);
    under_commit = (level_i <= cfg_commit_i);
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic fc_q, fc_d, release_now;

    always_comb begin
      release_now = cfg_release_i[p] ? under_commit : at_empty;
      fc_d        = fc_q;
      if (init_i) begin
        fc_d = 1'b0;
      end else if (set_i[p]) begin
        fc_d = 1'b1;
      end else if (fc_q && release_now) begin
        fc_d = 1'b0;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fc_q <= 1'b0;
      end else begin
        fc_q <= fc_d;
      end
    end

    assign fc_o[p] = fc_q;

    AST_FC_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[p] && !init_i) |=> fc_q); // R8
    AST_FC_HOLD_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fc_q && !cfg_release_i[p] && (level_i != '0) && !init_i) |=> fc_q); // R9
    AST_FC_INIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      init_i |=> !fc_q); // R10
  end

endmodule

// File: rtl/ingress_bucket_policer.sv
module ingress_bucket_policer
  import ibp_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int LEN_W      = 12,
  parameter int INC_W      = 12,
  parameter int RATE_W     = 16,
  parameter int LEVEL_W    = 24,
  parameter int PORT_IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  init_i,
  input  logic                  tick_i,
  input  logic                  frm_valid_i,
  input  logic [PORT_IDX_W-1:0] frm_port_i,
  input  logic [LEN_W-1:0]      frm_len_i,
  input  logic                  frm_filtered_i,
  input  logic                  frm_qdrop_i,
  input  logic [INC_W-1:0]      cfg_incr_i,
  input  logic [RATE_W-1:0]     cfg_rate_i,
  input  logic [LEVEL_W-1:0]    cfg_commit_i,
  input  logic [LEVEL_W-1:0]    cfg_excess_i,
  input  logic                  cfg_fc_mode_i,
  input  logic [NUM_PORTS-1:0]  cfg_release_i,
  input  logic [NUM_PORTS-1:0]  cfg_member_i,
  input  logic [3:0]            cfg_ovh_i,
  input  logic                  cfg_chg_filt_i,
  input  logic                  cfg_chg_qdrop_i,
  output logic                  verdict_valid_o,
  output logic                  verdict_drop_o,
  output logic [NUM_PORTS-1:0]  fc_req_o
);

  localparam int CHG_W = LEN_W + 1 + INC_W;
  localparam int SUM_W = ((CHG_W > LEVEL_W) ? CHG_W : LEVEL_W) + 1;

  // Reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_ns;
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_ns     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ns     <= rst_meta_q;
    end
  end

  logic               charge_en, over;
  logic [CHG_W-1:0]   charge;
  logic [LEVEL_W-1:0] level;
  logic [NUM_PORTS-1:0] fc_set;

  ibp_charge_calc #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_IDX_W(PORT_IDX_W),
    .LEN_W     (LEN_W),
    .INC_W     (INC_W),
    .CHG_W     (CHG_W)
  ) u_charge (
    .frm_valid_i    (frm_valid_i),
    .frm_port_i     (frm_port_i),
    .frm_len_i      (frm_len_i),
    .frm_filtered_i (frm_filtered_i),
    .frm_qdrop_i    (frm_qdrop_i),
    .init_i         (init_i),
    .cfg_member_i   (cfg_member_i),
    .cfg_ovh_i      (cfg_ovh_i),
    .cfg_incr_i     (cfg_incr_i),
    .cfg_chg_filt_i (cfg_chg_filt_i),
    .cfg_chg_qdrop_i(cfg_chg_qdrop_i),
    .charge_en_o    (charge_en),
    .charge_o       (charge)
  );

  ibp_bucket_level #(
    .LEVEL_W(LEVEL_W),
    .RATE_W (RATE_W),
    .CHG_W  (CHG_W),
    .SUM_W  (SUM_W)
  ) u_level (
    .clk_i        (clk_i),
    .rst_ni       (rst_ns),
    .init_i       (init_i),
    .tick_i       (tick_i),
    .charge_en_i  (charge_en),
    .charge_i     (charge),
    .cfg_rate_i   (cfg_rate_i),
    .cfg_excess_i (cfg_excess_i),
    .cfg_fc_mode_i(cfg_fc_mode_i),
    .level_o      (level),
    .over_o       (over)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_set
    assign fc_set[p] = charge_en && over && cfg_fc_mode_i &&
                       (frm_port_i == PORT_IDX_W'(p));
  end

  ibp_fc_tracker #(
    .NUM_PORTS(NUM_PORTS),
    .LEVEL_W  (LEVEL_W)
  ) u_fc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ns),
    .init_i       (init_i),
    .set_i        (fc_set),
    .level_i      (level),
    .cfg_commit_i (cfg_commit_i),
    .cfg_release_i(cfg_release_i),
    .fc_o         (fc_req_o)
  );

  // Verdict register
  logic vld_q, vld_d, drop_q, drop_d;

  always_comb begin
    vld_d  = frm_valid_i;
    drop_d = charge_en && over && !cfg_fc_mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ns) begin
    if (!rst_ns) begin
      vld_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      drop_q <= drop_d;
    end
  end

  assign verdict_valid_o = vld_q;
  assign verdict_drop_o  = drop_q;

  AST_VERDICT_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ns)
    frm_valid_i |=> verdict_valid_o); // R4
  AST_NO_STRAY_VERDICT: assert property (@(posedge clk_i) disable iff (!rst_ns)
    !frm_valid_i |=> !verdict_valid_o); // R4
  AST_FC_NEVER_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ns)
    (frm_valid_i && cfg_fc_mode_i) |=> !verdict_drop_o); // R8

endmodule

// File: tb/ingress_bucket_policer_tb_top.sv
module ingress_bucket_policer_tb_top;

  localparam int  CLK_PERIOD = 10;
  localparam int  NP   = 4;
  localparam int  LW   = 12;
  localparam int  IW   = 12;
  localparam int  RW   = 16;
  localparam int  VW   = 24;
  localparam longint LMAX = (64'd1 << VW) - 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_n, init, tick, fv, filt, qd;
  logic [1:0]    fport;
  logic [LW-1:0] flen;
  logic [IW-1:0] c_incr;
  logic [RW-1:0] c_rate;
  logic [VW-1:0] c_commit, c_excess;
  logic          c_fcmode, c_cf, c_cq;
  logic [NP-1:0] c_rel, c_member, fc_req;
  logic [3:0]    c_ovh;
  logic          v_valid, v_drop;

  ingress_bucket_policer dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .init_i(init), .tick_i(tick),
    .frm_valid_i(fv), .frm_port_i(fport), .frm_len_i(flen),
    .frm_filtered_i(filt), .frm_qdrop_i(qd),
    .cfg_incr_i(c_incr), .cfg_rate_i(c_rate), .cfg_commit_i(c_commit),
    .cfg_excess_i(c_excess), .cfg_fc_mode_i(c_fcmode), .cfg_release_i(c_rel),
    .cfg_member_i(c_member), .cfg_ovh_i(c_ovh), .cfg_chg_filt_i(c_cf),
    .cfg_chg_qdrop_i(c_cq), .verdict_valid_o(v_valid), .verdict_drop_o(v_drop),
    .fc_req_o(fc_req)
  );

  int     n_chk = 0, n_bad = 0;
  bit     done = 0;
  longint m_level = 0;
  logic   exp_q[$];
  string  tag_q[$];

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops one expected verdict per produced verdict
  always @(negedge clk) begin
    if (rst_n && v_valid) begin
      if (exp_q.size() == 0) begin
        check("R4 unexpected verdict", 1, 0);
      end else begin
        check(tag_q.pop_front(), v_drop, exp_q.pop_front());
      end
    end
  end

  // Driver: computes the expected verdict from the requirements
  task automatic frame(input int p, input int len, input bit f, input bit q,
                       input bit tk, input string req);
    longint base, sum;
    bit elig, over, drop;
    @(negedge clk);
    fv = 1; fport = 2'(p); flen = LW'(len); filt = f; qd = q; tick = tk;
    base = m_level;
    if (tk) base = (m_level > c_rate) ? m_level - c_rate : 0;
    elig = c_member[p] && (c_ovh == 1 || c_ovh == 2 || c_ovh == 6) &&
           (!f || c_cf) && (!q || c_cq);
    drop = 0;
    m_level = base;
    if (elig) begin
      sum = base + (longint'(len) + c_ovh) * c_incr;
      if (sum > LMAX) sum = LMAX;
      over = sum > c_excess;
      drop = over && !c_fcmode;
      if (!drop) m_level = sum;
    end
    exp_q.push_back(drop);
    tag_q.push_back(req);
    @(posedge clk); #1;
    fv = 0; filt = 0; qd = 0; tick = 0;
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      m_level = (m_level > c_rate) ? m_level - c_rate : 0;
      @(posedge clk); #1; tick = 0;
    end
  endtask

  task automatic do_init();
    @(negedge clk); init = 1; m_level = 0;
    @(posedge clk); #1; init = 0;
  endtask

  task automatic chk_fc(input logic [NP-1:0] exp, input string req);
    @(posedge clk); @(negedge clk);
    check(req, fc_req, exp);
  endtask

  initial begin
    rst_n = 0; init = 0; tick = 0; fv = 0; filt = 0; qd = 0; fport = 0; flen = 0;
    c_incr = 1; c_rate = 100; c_commit = 500; c_excess = 1000; c_fcmode = 0;
    c_cf = 0; c_cq = 0; c_rel = 4'b0010; c_member = 4'b0011; c_ovh = 2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R11 fc after reset", fc_req, 0);
    check("R11 verdict_valid after reset", v_valid, 0);

    // Drop mode accumulation and boundary
    frame(0, 298, 0, 0, 0, "R1 charge 300");
    frame(1, 298, 0, 0, 0, "R1 shared port charge");
    frame(0, 298, 0, 0, 0, "R1 level 900");
    frame(0, 298, 0, 0, 0, "R5 over limit dropped");
    frame(0, 98, 0, 0, 0, "R4 equal to limit passes");
    frame(2, 1000, 0, 0, 0, "R6 non-member not dropped");
    frame(0, 0, 0, 0, 0, "R6 non-member left level unchanged");
    do_tick(3);
    frame(0, 298, 0, 0, 0, "R3 drained by ticks");
    frame(0, 98, 0, 0, 1, "R3 drain before charge");
    do_tick(11);
    frame(0, 998, 0, 0, 0, "R3 floor at zero");
    // Filter / congestion charge enables
    frame(0, 100, 1, 0, 0, "R7 filtered not charged");
    frame(0, 0, 0, 0, 0, "R7 level after uncharged filtered");
    c_cf = 1;
    frame(0, 100, 1, 0, 0, "R7 filtered charged when enabled");
    frame(0, 100, 0, 1, 0, "R7 qdrop not charged");
    c_cq = 1;
    frame(0, 100, 0, 1, 0, "R7 qdrop charged when enabled");
    // Overhead codes
    c_ovh = 3;
    frame(0, 2000, 0, 0, 0, "R6 invalid overhead not dropped");
    c_ovh = 1;
    do_init();
    frame(0, 999, 0, 0, 0, "R1 overhead 1 reaches limit");
    frame(0, 0, 0, 0, 0, "R1 overhead 1 over limit");
    // Saturation
    do_init();
    c_ovh = 6; c_incr = 12'hFFF; c_excess = 24'hFFFFFF;
    frame(0, 4095, 0, 0, 0, "R2 saturating frame passes");
    c_excess = 24'hFFFFFE;
    frame(0, 0, 0, 0, 0, "R2 level held at maximum");
    // Init clears level
    do_init();
    c_ovh = 2; c_incr = 1; c_excess = 1000;
    frame(1, 998, 0, 0, 0, "R10 level cleared by init");
    frame(1, 0, 0, 0, 0, "R10 level exact after init");
    // Flow-control mode
    do_init();
    c_fcmode = 1;
    frame(0, 998, 0, 0, 0, "R8 under limit");
    frame(1, 98, 0, 0, 0, "R8 over limit passes");
    chk_fc(4'b0010, "R8 fc raised on port 1");
    frame(0, 0, 0, 0, 0, "R8 second over-limit frame");
    chk_fc(4'b0011, "R8 fc raised on port 0");
    do_tick(5);
    chk_fc(4'b0011, "R9 held above commit");
    do_tick(1);
    chk_fc(4'b0011, "R9 held at 502");
    do_tick(1);
    chk_fc(4'b0001, "R9 commit release on port 1");
    do_tick(4);
    chk_fc(4'b0001, "R9 empty release waits for zero");
    do_tick(1);
    chk_fc(4'b0000, "R9 empty release on port 0");
    frame(0, 1000, 0, 0, 0, "R8 over again");
    chk_fc(4'b0001, "R8 fc raised again");
    do_init();
    @(negedge clk);
    check("R10 fc cleared by init", fc_req, 0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 all verdicts returned", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule